// File: doc/BRIEF.md
# Sixteen-Bit Two-Level Lookahead Adder

This block adds two 16-bit operands and a carry input within one combinational path. The operand bits form four slices of four bits each. Every slice computes the carries it needs internally from per-bit generate and propagate terms and its own carry input, so no carry ripples from bit to bit. Every slice also reports a slice-level generate and propagate pair to a second lookahead stage. That stage computes the carry into slices 1, 2 and 3 and the final carry out. It works directly from those pairs and the adder's carry input, so no carry ripples from slice to slice either.

The per-bit and per-slice generate and propagate terms are brought out as observation ports. This lets a bench or a debug path check the carry structure as well as the arithmetic result. A bit generates a carry when both operand bits are 1. A bit propagates a carry when at least one operand bit is 1; propagate is the inclusive-OR form. Because of that, each sum bit is computed as the XOR of both operand bits and the incoming carry, and never from the propagate term.

Top module: `cla16_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + c_i` for every input combination.
- R2: `co_o` equals bit 16 of the 17-bit value `a_i + b_i + c_i`.
- R3: `bit_gen_o[n]` equals `a_i[n] & b_i[n]` for every bit position n.
- R4: `bit_prop_o[n]` equals `a_i[n] | b_i[n]` for every bit position n.
- R5: `grp_prop_o[k]` is 1 exactly when all four `bit_prop_o` bits of slice k are 1. Slice k covers bits 4k+3 down to 4k.
- R6: `grp_gen_o[k]` equals the carry out of slice k when that slice's carry input is 0. That is bit 4 of `a_i[4k+3:4k] + b_i[4k+3:4k]`.
- R7: `co_o` equals G3 | P3·G2 | P3·P2·G1 | P3·P2·P1·G0 | P3·P2·P1·P0·`c_i`, with G and P taken from `grp_gen_o` and `grp_prop_o`.
- R8: With `a_i` = 16'h1A33, `b_i` = 16'hE5EB and `c_i` = 0, the outputs are `bit_gen_o` = 16'h0023, `bit_prop_o` = 16'hFFFB, `grp_gen_o` = 4'b0010, `grp_prop_o` = 4'b1110, `sum_o` = 16'h001E and `co_o` = 1.
- R9: With `a_i` = 16'hFFFF, `b_i` = 0 and `c_i` = 1, the carry travels through all four slices: `sum_o` = 0, `co_o` = 1 and `grp_prop_o` = 4'b1111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| c_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum, modulo 2^16 |
| co_o | output | 1 | Carry out of bit 15 |
| bit_gen_o | output | 16 | Per-bit generate terms |
| bit_prop_o | output | 16 | Per-bit propagate terms (OR form) |
| grp_gen_o | output | 4 | Slice generate terms |
| grp_prop_o | output | 4 | Slice propagate terms |

## Verification
The bound checker re-evaluates R1 through R7 whenever any input changes, against plain arithmetic and bitwise references. That covers the sum, the carry out, both sets of per-bit terms, both sets of slice terms, and the consistency of the second-level carry with the slice pairs. Only the bench's chosen scenarios can show R8 and R9, which are the exact values for the worked operand pair and the full-length carry travel from all ones plus a carry in. The bench's random vectors show that no mix of generate and propagate patterns across slices breaks the result.

// File: rtl/cla16_pkg.sv
package cla16_pkg;
    localparam int unsigned SLICE_W   = 4;
    localparam int unsigned SLICE_NUM = 4;
    localparam int unsigned ADD_W     = SLICE_W * SLICE_NUM;
endpackage

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] gen_i,
    input  logic [N-1:0] prop_i,
    input  logic         cin_i,
    output logic [N:0]   carry_o
);
    // Every carry is a flat sum of products over gen, prop and cin.
    always_comb begin
        logic acc;
        logic term;
        carry_o[0] = cin_i;
        for (int j = 1; j <= N; j++) begin
            acc = 1'b0;
            for (int m = 0; m < j; m++) begin
                term = gen_i[m];
                for (int k = m + 1; k < j; k++) begin
                    term = term & prop_i[k];
                end
                acc = acc | term;
            end
            term = cin_i;
            for (int k = 0; k < j; k++) begin
                term = term & prop_i[k];
            end
            carry_o[j] = acc | term;
        end
    end
endmodule

// File: rtl/cla_slice.sv
module cla_slice #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] gen_o,
    output logic [W-1:0] prop_o,
    output logic         grp_gen_o,
    output logic         grp_prop_o
);
    logic [W:0] carry;
    logic [W:0] carry_nocin;

    assign gen_o  = a_i & b_i;
    assign prop_o = a_i | b_i;

    cla_lookahead #(.N(W)) u_inner (
        .gen_i  (gen_o),
        .prop_i (prop_o),
        .cin_i  (cin_i),
        .carry_o(carry)
    );

    // Slice generate: the same product terms with the carry-in term removed.
    cla_lookahead #(.N(W)) u_grp (
        .gen_i  (gen_o),
        .prop_i (prop_o),
        .cin_i  (1'b0),
        .carry_o(carry_nocin)
    );

    assign grp_gen_o  = carry_nocin[W];
    assign grp_prop_o = &prop_o;
    assign sum_o      = a_i ^ b_i ^ carry[W-1:0];
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
    import cla16_pkg::*;
(
    input  logic [15:0] a_i,
    input  logic [15:0] b_i,
    input  logic        c_i,
    output logic [15:0] sum_o,
    output logic        co_o,
    output logic [15:0] bit_gen_o,
    output logic [15:0] bit_prop_o,
    output logic [3:0]  grp_gen_o,
    output logic [3:0]  grp_prop_o
);
    logic [SLICE_NUM:0] slice_carry;

    cla_lookahead #(.N(SLICE_NUM)) u_level2 (
        .gen_i  (grp_gen_o),
        .prop_i (grp_prop_o),
        .cin_i  (c_i),
        .carry_o(slice_carry)
    );

    for (genvar s = 0; s < SLICE_NUM; s++) begin : g_slice
        cla_slice #(.W(SLICE_W)) u_slice (
            .a_i       (a_i[s*SLICE_W +: SLICE_W]),
            .b_i       (b_i[s*SLICE_W +: SLICE_W]),
            .cin_i     (slice_carry[s]),
            .sum_o     (sum_o[s*SLICE_W +: SLICE_W]),
            .gen_o     (bit_gen_o[s*SLICE_W +: SLICE_W]),
            .prop_o    (bit_prop_o[s*SLICE_W +: SLICE_W]),
            .grp_gen_o (grp_gen_o[s]),
            .grp_prop_o(grp_prop_o[s])
        );
    end

    assign co_o = slice_carry[SLICE_NUM];
endmodule

// File: rtl/cla16_checker.sv
module cla16_checker (
    input logic [15:0] a_i,
    input logic [15:0] b_i,
    input logic        c_i,
    input logic [15:0] sum_o,
    input logic        co_o,
    input logic [15:0] bit_gen_o,
    input logic [15:0] bit_prop_o,
    input logic [3:0]  grp_gen_o,
    input logic [3:0]  grp_prop_o
);
    always_comb begin
        logic [16:0] ref_total;
        logic [4:0]  nib;
        ref_total = {1'b0, a_i} + {1'b0, b_i} + {16'd0, c_i};
        assert_sum_R1: assert (sum_o == ref_total[15:0]);
        assert_carry_R2: assert (co_o == ref_total[16]);
        assert_bitgen_R3: assert (bit_gen_o == (a_i & b_i));
        assert_bitprop_R4: assert (bit_prop_o == (a_i | b_i));
        for (int k = 0; k < 4; k++) begin
            nib = {1'b0, a_i[4*k +: 4]} + {1'b0, b_i[4*k +: 4]};
            assert_grpprop_R5: assert (grp_prop_o[k] == (bit_prop_o[4*k +: 4] == 4'hF));
            assert_grpgen_R6: assert (grp_gen_o[k] == nib[4]);
        end
        assert_level2_R7: assert (co_o == (grp_gen_o[3]
            | (grp_prop_o[3] & grp_gen_o[2])
            | (grp_prop_o[3] & grp_prop_o[2] & grp_gen_o[1])
            | (grp_prop_o[3] & grp_prop_o[2] & grp_prop_o[1] & grp_gen_o[0])
            | (&grp_prop_o & c_i)));
    end
endmodule

bind cla16_adder cla16_checker u_chk (
    .a_i       (a_i),
    .b_i       (b_i),
    .c_i       (c_i),
    .sum_o     (sum_o),
    .co_o      (co_o),
    .bit_gen_o (bit_gen_o),
    .bit_prop_o(bit_prop_o),
    .grp_gen_o (grp_gen_o),
    .grp_prop_o(grp_prop_o)
);

// File: tb/sim_cla16_adder.sv
module sim_cla16_adder;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [15:0] a, b, sum, bg, bp;
    logic        ci, co;
    logic [3:0]  gg, gp;

    cla16_adder u0 (
        .a_i(a), .b_i(b), .c_i(ci), .sum_o(sum), .co_o(co),
        .bit_gen_o(bg), .bit_prop_o(bp), .grp_gen_o(gg), .grp_prop_o(gp)
    );

    typedef struct packed {
        logic [15:0] sum;
        logic        co;
        logic [15:0] bg;
        logic [15:0] bp;
        logic [3:0]  gg;
        logic [3:0]  gp;
        logic [7:0]  tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: applies one vector per cycle and queues independent expectations.
    task automatic drive(input logic [15:0] av, input logic [15:0] bv, input logic cv, input logic [7:0] tag);
        exp_t e;
        logic [16:0] tot;
        logic [4:0]  nib;
        @(posedge clk);
        a = av; b = bv; ci = cv;
        tot = {1'b0, av} + {1'b0, bv} + {16'd0, cv};
        e.sum = tot[15:0];
        e.co  = tot[16];
        e.bg  = av & bv;
        e.bp  = av | bv;
        for (int k = 0; k < 4; k++) begin
            nib = {1'b0, av[4*k +: 4]} + {1'b0, bv[4*k +: 4]};
            e.gg[k] = nib[4];
            e.gp[k] = &(av[4*k +: 4] | bv[4*k +: 4]);
        end
        e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compares the settled outputs at the falling edge.
    always @(negedge clk) begin
        if (!rst && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check("R1 sum", {16'd0, sum}, {16'd0, e.sum});
            check("R2 carry out", {31'd0, co}, {31'd0, e.co});
            check("R3 bit generate", {16'd0, bg}, {16'd0, e.bg});
            check("R4 bit propagate", {16'd0, bp}, {16'd0, e.bp});
            check("R5 slice propagate", {28'd0, gp}, {28'd0, e.gp});
            check("R6 slice generate", {28'd0, gg}, {28'd0, e.gg});
            check("R7 second-level carry", {31'd0, co}, {31'd0, (gg[3] | (gp[3] & gg[2])
                | (gp[3] & gp[2] & gg[1]) | (gp[3] & gp[2] & gp[1] & gg[0]) | (&gp & ci))});
            if (e.tag == 8'd1) begin
                check("R8 worked pair generate", {16'd0, bg}, 32'h0023);
                check("R8 worked pair propagate", {16'd0, bp}, 32'hFFFB);
                check("R8 worked pair slice generate", {28'd0, gg}, 32'h2);
                check("R8 worked pair slice propagate", {28'd0, gp}, 32'hE);
                check("R8 worked pair sum", {16'd0, sum}, 32'h001E);
                check("R8 worked pair carry", {31'd0, co}, 32'h1);
            end
            if (e.tag == 8'd2) begin
                check("R9 full travel sum", {16'd0, sum}, 32'h0);
                check("R9 full travel carry", {31'd0, co}, 32'h1);
                check("R9 full travel slice propagate", {28'd0, gp}, 32'hF);
            end
            if (e.tag == 8'd3) begin
                check("R1 zero inputs after reset", {16'd0, sum}, 32'h0);
            end
        end
    end

    initial begin
        a = '0; b = '0; ci = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        drive(16'h0000, 16'h0000, 1'b0, 8'd3);
        drive(16'h1A33, 16'hE5EB, 1'b0, 8'd1);
        drive(16'hFFFF, 16'h0000, 1'b1, 8'd2);
        drive(16'hFFFF, 16'h0001, 1'b0, 8'd0);
        drive(16'hFFFF, 16'hFFFF, 1'b1, 8'd0);
        drive(16'h8000, 16'h8000, 1'b0, 8'd0);
        drive(16'h0FFF, 16'h0001, 1'b0, 8'd0);
        drive(16'hF0F0, 16'h0F0F, 1'b1, 8'd0);
        for (int i = 0; i < 300; i++) begin
            drive(16'($urandom), 16'($urandom), 1'($urandom), 8'd0);
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
    end

    initial begin
        int cycles;
        cycles = 0;
        while (!done && cycles < 5000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule